// File: doc/BRIEF.md
# Cell Receive Interrupt Status Register

This block gathers the error and condition events of a cell-based physical-layer receiver into one 8-bit status byte, along with an interrupt request. Other blocks detect the events: the symbol decoder, the header checksum checker, the receive FIFO and the transmit path. Each one sends a one-cycle strobe. The status register latches every strobe into its own sticky flag. The flag holds until software reads the byte.

The block also derives two events of its own. It counts received byte strobes between consecutive start-of-cell markers and flags a cell that is too short. It watches the signal-good level and flags every change in either direction. When checking is enabled, it also checks odd parity on each transmit byte. The receive and transmit byte streams are only observed. The block has no ready signal, never applies back-pressure and never stalls either stream. A byte counts only in a cycle where its valid strobe is high.

The status byte is readable at all times. A one-cycle read strobe clears all sticky flags at the next clock edge. An event that arrives in the same cycle as the read strobe stays latched.

Top module: `cell_rx_irq_status`

## Requirements
- R1: Bit 7 of `stat_byte` always reads 0. Bit 6 always equals the present `sig_good` input (1 = good signal, 0 = bad) and is never sticky.
- R2: Each sticky flag has a fixed position: bit 5 header checksum error, bit 4 short cell, bit 3 transmit parity error, bit 2 signal change, bit 1 undefined symbol, bit 0 receive FIFO overrun.
- R3: A high `hec_err_pulse`, `sym_err_pulse` or `fifo_ovr_pulse` in a cycle sets bit 5, 1 or 0 after that clock edge. The bit stays set until a read clears it.
- R4: A received byte carrying `rx_soc` counts as byte 1 of its cell. When a start-of-cell byte arrives and fewer than 53 bytes have been counted since the previous start-of-cell byte, bit 4 sets. The first start-of-cell byte after reset never sets it.
- R5: A cell of 53 or more bytes does not set bit 4. Every start-of-cell byte restarts the count.
- R6: Bit 2 sets whenever `sig_good` differs from its value in the previous cycle, for both good-to-bad and bad-to-good changes. The first cycle after reset only captures the level and does not set bit 2.
- R7: When `tx_par_chk_en` is 1, a transmit byte whose 8 data bits plus `tx_par` hold an even number of ones sets bit 3. When `tx_par_chk_en` is 0, bit 3 never sets.
- R8: `stat_rd` high in a cycle clears bits 5 to 0 at that clock edge. Any event in the same cycle still leaves its flag set.
- R9: `irq` is 1 exactly when at least one of bits 5 to 0 is set.
- R10: While `rst_n` is low, bits 5 to 0 are 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_byte_vld | input | 1 | A received byte is transferred this cycle |
| rx_soc | input | 1 | The received byte is the first of a cell (valid with rx_byte_vld) |
| hec_err_pulse | input | 1 | Header checksum error strobe |
| sym_err_pulse | input | 1 | Undefined line symbol strobe |
| fifo_ovr_pulse | input | 1 | Receive FIFO overrun strobe |
| tx_byte_vld | input | 1 | A transmit byte is transferred this cycle |
| tx_byte | input | 8 | Transmit data byte |
| tx_par | input | 1 | Odd-parity bit accompanying tx_byte |
| tx_par_chk_en | input | 1 | Enables the transmit parity check |
| sig_good | input | 1 | Live receive signal quality, 1 = good |
| stat_rd | input | 1 | Read strobe that clears the sticky flags |
| stat_byte | output | 8 | Status byte |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the embedded assertions check four things. A latched flag holds until a read. A read with no concurrent event empties the register. The parity flag cannot rise while checking is disabled. The cell counter never runs past one cell length. Exact cell-length boundaries can only be shown by the bench's scenarios: 52 against 53 bytes, gaps in the byte strobe, and the first marker after reset. The same holds for the event that coincides with a read, for both directions of signal change, and for the parity outcome on chosen bytes. A behavioural model checks each of these every cycle.

// File: rtl/cell_irq_pkg.sv
package cell_irq_pkg;
  localparam int unsigned STATUS_W   = 8;
  localparam int unsigned NUM_STICKY = 6;
  localparam int unsigned POS_OVR    = 0;
  localparam int unsigned POS_SYM    = 1;
  localparam int unsigned POS_CHG    = 2;
  localparam int unsigned POS_PAR    = 3;
  localparam int unsigned POS_SHORT  = 4;
  localparam int unsigned POS_HEC    = 5;
  localparam int unsigned POS_SIG    = 6;
  typedef logic [NUM_STICKY-1:0] sticky_vec_t;
endpackage

// File: rtl/cell_len_monitor.sv
module cell_len_monitor #(
  parameter int unsigned CELL_BYTES = 53
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_vld_i,
  input  logic rx_soc_i,
  output logic short_o
);
  localparam int unsigned CNT_W = $clog2(CELL_BYTES + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(CELL_BYTES);

  logic [CNT_W-1:0] cnt_q;
  logic             seen_soc_q;
  logic             soc_byte;

  assign soc_byte = rx_vld_i && rx_soc_i;
  assign short_o  = soc_byte && seen_soc_q && (cnt_q < CNT_FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      seen_soc_q <= 1'b0;
    end else if (soc_byte) begin
      cnt_q      <= CNT_W'(1);
      seen_soc_q <= 1'b1;
    end else if (rx_vld_i && (cnt_q != CNT_FULL)) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // R5: the count saturates at one cell length
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);
  // R4: a short-cell event only occurs on a start-of-cell byte
  p_short_on_soc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    short_o |-> (rx_vld_i && rx_soc_i));
endmodule

// File: rtl/odd_parity_check.sv
module odd_parity_check #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              vld_i,
  input  logic              en_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              par_i,
  output logic              err_o
);
  logic ones_odd;
  assign ones_odd = ^{data_i, par_i};
  assign err_o    = vld_i && en_i && !ones_odd;
endmodule

// File: rtl/level_change_detect.sv
module level_change_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic chg_o
);
  logic level_q;
  logic primed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q  <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      level_q  <= level_i;
      primed_q <= 1'b1;
    end
  end

  assign chg_o = primed_q && (level_i != level_q);

  // R6: once primed, the detector stays primed
  p_primed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    primed_q |=> primed_q);
endmodule

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
  parameter int unsigned N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] q_r;

  for (genvar gi = 0; gi < N; gi++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_r[gi] <= 1'b0;
      else        q_r[gi] <= (q_r[gi] && !clr_i) || set_i[gi];
    end
  end

  assign q_o = q_r;

  // R3: without a read, a set flag stays set
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((q_r & $past(q_r)) == $past(q_r)));
  // R3: an event is latched at the next edge
  p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((q_r & $past(set_i)) == $past(set_i)));
  // R8: a read with no concurrent event empties the bank
  p_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !(|set_i)) |=> (q_r == '0));
endmodule

// File: rtl/cell_rx_irq_status.sv
module cell_rx_irq_status
  import cell_irq_pkg::*;
#(
  parameter int unsigned CELL_BYTES = 53,
  parameter int unsigned TX_W       = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx_byte_vld,
  input  logic            rx_soc,
  input  logic            hec_err_pulse,
  input  logic            sym_err_pulse,
  input  logic            fifo_ovr_pulse,
  input  logic            tx_byte_vld,
  input  logic [TX_W-1:0] tx_byte,
  input  logic            tx_par,
  input  logic            tx_par_chk_en,
  input  logic            sig_good,
  input  logic            stat_rd,
  output logic [STATUS_W-1:0] stat_byte,
  output logic            irq
);
  logic        short_ev;
  logic        par_ev;
  logic        chg_ev;
  sticky_vec_t ev_vec;
  sticky_vec_t flags;

  cell_len_monitor #(.CELL_BYTES(CELL_BYTES)) u_len (
    .clk(clk), .rst_n(rst_n), .rx_vld_i(rx_byte_vld), .rx_soc_i(rx_soc),
    .short_o(short_ev)
  );

  odd_parity_check #(.DATA_W(TX_W)) u_par (
    .vld_i(tx_byte_vld), .en_i(tx_par_chk_en), .data_i(tx_byte),
    .par_i(tx_par), .err_o(par_ev)
  );

  level_change_detect u_chg (
    .clk(clk), .rst_n(rst_n), .level_i(sig_good), .chg_o(chg_ev)
  );

  always_comb begin
    ev_vec            = '0;
    ev_vec[POS_HEC]   = hec_err_pulse;
    ev_vec[POS_SHORT] = short_ev;
    ev_vec[POS_PAR]   = par_ev;
    ev_vec[POS_CHG]   = chg_ev;
    ev_vec[POS_SYM]   = sym_err_pulse;
    ev_vec[POS_OVR]   = fifo_ovr_pulse;
  end

  irq_sticky_bank #(.N(NUM_STICKY)) u_bank (
    .clk(clk), .rst_n(rst_n), .set_i(ev_vec), .clr_i(stat_rd), .q_o(flags)
  );

  always_comb begin
    stat_byte                   = '0;
    stat_byte[NUM_STICKY-1:0]   = flags;
    stat_byte[POS_SIG]          = sig_good;
  end

  assign irq = |flags;

  // R7: with checking disabled and no read, the parity flag cannot change
  p_par_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_par_chk_en && !stat_rd) |=> (stat_byte[POS_PAR] == $past(stat_byte[POS_PAR])));
  // R9: an active request persists until a read
  p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !stat_rd) |=> irq);
endmodule

// File: tb/cell_rx_irq_status_tb.sv
module cell_rx_irq_status_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_byte_vld = 0, rx_soc = 0, hec_err_pulse = 0, sym_err_pulse = 0;
  logic fifo_ovr_pulse = 0, tx_byte_vld = 0, tx_par = 0, tx_par_chk_en = 0;
  logic sig_good = 1'b1, stat_rd = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic [7:0] stat_byte;
  logic       irq;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  logic [5:0] m_flags = '0;
  int  m_cnt = 0;
  bit  m_seen = 0;
  bit  m_primed = 0;
  bit  m_prev = 0;

  always #10 clk = ~clk;

  cell_rx_irq_status dut_i (
    .clk(clk), .rst_n(rst_n), .rx_byte_vld(rx_byte_vld), .rx_soc(rx_soc),
    .hec_err_pulse(hec_err_pulse), .sym_err_pulse(sym_err_pulse),
    .fifo_ovr_pulse(fifo_ovr_pulse), .tx_byte_vld(tx_byte_vld),
    .tx_byte(tx_byte), .tx_par(tx_par), .tx_par_chk_en(tx_par_chk_en),
    .sig_good(sig_good), .stat_rd(stat_rd), .stat_byte(stat_byte), .irq(irq)
  );

  task automatic model_step();
    logic [5:0] ev;
    if (!rst_n) begin
      m_flags = '0; m_cnt = 0; m_seen = 0; m_primed = 0; m_prev = 0;
      return;
    end
    ev = '0;
    ev[5] = hec_err_pulse;
    ev[1] = sym_err_pulse;
    ev[0] = fifo_ovr_pulse;
    if (tx_byte_vld && tx_par_chk_en && (($countones({tx_byte, tx_par}) % 2) == 0)) ev[3] = 1;
    if (m_primed && (sig_good != m_prev)) ev[2] = 1;
    if (rx_byte_vld) begin
      if (rx_soc) begin
        if (m_seen && m_cnt < 53) ev[4] = 1;
        m_cnt = 1; m_seen = 1;
      end else begin
        m_cnt++;
      end
    end
    m_flags = (stat_rd ? 6'b0 : m_flags) | ev;
    m_prev = sig_good;
    m_primed = 1;
  endtask

  task automatic compare(input string tag);
    logic [7:0] exp_b;
    exp_b = {1'b0, sig_good, m_flags};
    vectors++;
    if (stat_byte !== exp_b) begin
      miscompares++;
      $display("FAIL %s stat_byte actual=%b expected=%b t=%0t", tag, stat_byte, exp_b, $time);
    end
    vectors++;
    if (irq !== (|m_flags)) begin
      miscompares++;
      $display("FAIL %s irq actual=%b expected=%b t=%0t", tag, irq, |m_flags, $time);
    end
  endtask

  task automatic idle_inputs();
    rx_byte_vld = 0; rx_soc = 0; hec_err_pulse = 0; sym_err_pulse = 0;
    fifo_ovr_pulse = 0; tx_byte_vld = 0; stat_rd = 0;
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(tag);
    idle_inputs();
  endtask

  task automatic send_cell(input int nbytes, input int gap, input string tag);
    for (int i = 0; i < nbytes; i++) begin
      rx_byte_vld = 1; rx_soc = (i == 0);
      tick(tag);
      for (int g = 0; g < gap; g++) tick(tag);
    end
  endtask

  task automatic read_clear(input string tag);
    stat_rd = 1;
    tick(tag);
  endtask

  task automatic finish_run();
    if (done) return;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    miscompares++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    @(negedge clk);
    // R10 / R1: reset state
    for (int i = 0; i < 3; i++) begin hec_err_pulse = 1; tick("R10"); end
    rst_n = 1;
    tick("R6");              // first cycle after reset: capture only
    tick("R1");
    sig_good = 0; tick("R6"); // good to bad
    tick("R6");
    read_clear("R8");
    sig_good = 1; tick("R6"); // bad to good
    read_clear("R8");
    hec_err_pulse = 1; tick("R3");
    repeat (3) tick("R3");
    sym_err_pulse = 1; tick("R2");
    fifo_ovr_pulse = 1; tick("R2");
    tick("R9");
    read_clear("R8");
    tick("R9");
    stat_rd = 1; hec_err_pulse = 1; tick("R8"); // event kept on read
    tick("R8");
    read_clear("R8");
    // R4: first marker after reset never flags, short cell then flags
    send_cell(52, 0, "R4");
    send_cell(52, 1, "R4");
    send_cell(1, 0, "R4");
    read_clear("R8");
    // R5: exact and long cells
    send_cell(53, 0, "R5");
    send_cell(53, 2, "R5");
    send_cell(70, 0, "R5");
    send_cell(1, 0, "R5");
    read_clear("R8");
    // R7: parity disabled, odd ok, even error
    tx_par_chk_en = 0; tx_byte_vld = 1; tx_byte = 8'h03; tx_par = 0; tick("R7");
    tx_par_chk_en = 1; tx_byte_vld = 1; tx_byte = 8'h03; tx_par = 1; tick("R7");
    tx_byte_vld = 1; tx_byte = 8'h00; tx_par = 1; tick("R7");
    tx_byte_vld = 0; tx_byte = 8'h00; tx_par = 0; tick("R7");
    tx_byte_vld = 1; tx_byte = 8'hA5; tx_par = 0; tick("R7");
    read_clear("R8");
    // Mixed random traffic
    for (int c = 0; c < 4000; c++) begin
      rx_byte_vld    = ($urandom % 10) < 7;
      rx_soc         = rx_byte_vld && (($urandom % 45) == 0);
      hec_err_pulse  = ($urandom % 60) == 0;
      sym_err_pulse  = ($urandom % 60) == 0;
      fifo_ovr_pulse = ($urandom % 60) == 0;
      tx_byte_vld    = ($urandom % 3) == 0;
      tx_byte        = 8'($urandom);
      tx_par         = 1'($urandom);
      tx_par_chk_en  = ($urandom % 4) != 0;
      if (($urandom % 50) == 0) sig_good = ~sig_good;
      stat_rd        = ($urandom % 12) == 0;
      tick("R2");
    end
    finish_run();
  end
endmodule